// File: doc/BRIEF.md
# Banked Scratchpad Crossbar with Round-Robin Bank Arbitration

This block joins a group of processing-element request ports to a shared, word-interleaved data scratchpad built from several single-ported banks. Each port raises a request with an address, a write flag and write data. The block decides within the same cycle whether the address lies in the local scratchpad window. A local request goes to the bank chosen by the low word-address bits. Any other request goes to a single external-memory request port, which passes it through unchanged.

Each bank and the external port has its own round-robin arbiter. Requests to different banks are all granted in the same cycle. Requests that collide on a bank are granted one per cycle, back to back, with no gap between them. When the winning request is a read, every other read to the same word is granted along with it and receives the same data. A local request that has been granted is answered two cycles after its grant cycle. A port keeps its request asserted until it sees its grant.

Top module: `spm_xbar`

## Requirements
- R1: A request whose byte address A satisfies LOCAL_BASE <= A < LOCAL_BASE + N_BANKS*BANK_WORDS*(DATA_W/8) is local. Any other request is external. The external port presents the address, write flag, write data and requesting port index of one external request in the same cycle. The requesting port's grant equals `ext_gnt` in that cycle.
- R2: For a local request, word index w = (A - LOCAL_BASE) >> log2(DATA_W/8). The bank is w mod N_BANKS and the row is w / N_BANKS, so consecutive words fall in consecutive banks.
- R3: Each bank's arbiter starts at port 0 after reset. It picks the first requesting port at or after its pointer, in increasing order with wrap-around. After a grant, it moves its pointer to one past the winner. It moves the pointer only in cycles where it grants.
- R4: While any port requests a bank, that bank grants one request in that cycle. K colliding requests that are held until granted are therefore all granted within K consecutive cycles.
- R5: Local requests to distinct banks are all granted in the same cycle.
- R6: When the winner of a bank is a read, every other port reading the same word in that cycle is granted in that cycle and receives the same read data.
- R7: A write is never merged. When a write wins a bank, it is the only grant for that bank in that cycle. A write to a word is not granted together with reads of that word.
- R8: A local request granted in cycle T raises `resp_valid` for its port in cycle T+2. For a read, `resp_rdata` carries the word most recently written at that address before cycle T. External requests produce no `resp_valid`.
- R9: After reset, and with no requests, every grant, every `resp_valid` and `ext_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | N_PORTS | Request per port |
| we | input | N_PORTS | Write flag per port (1 = write) |
| addr | input | N_PORTS*ADDR_W | Byte address per port, port p in bits [p*ADDR_W +: ADDR_W] |
| wdata | input | N_PORTS*DATA_W | Write data per port |
| gnt | output | N_PORTS | Grant per port, combinational in the request cycle |
| resp_valid | output | N_PORTS | Response strobe, two cycles after a local grant |
| resp_rdata | output | N_PORTS*DATA_W | Read data per port (zero for writes) |
| ext_req | output | 1 | External-memory request |
| ext_port | output | max(1,log2 N_PORTS) | Index of the port forwarded externally |
| ext_we | output | 1 | External write flag |
| ext_addr | output | ADDR_W | External byte address |
| ext_wdata | output | DATA_W | External write data |
| ext_gnt | input | 1 | External side accepts the forwarded request |

## Verification
Several properties are checked on every cycle. Grants go only to requesting ports. A bank with a pending request always grants something. A granted write is the only grant of its bank. Each response strobe follows a local grant by exactly two cycles. The external port never carries a local address. Only the bench scenarios can show the rest: the actual round-robin order, the wrap of the pointer past the last winner, the data returned to merged readers, and the ordering of a write against reads of the same word. The bench shows these by sweeping every word of the memory through all ports and comparing against values it computes itself.

// File: rtl/spm_pkg.sv
package spm_pkg;
   // index width for a count of n items, never below one bit
   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   function automatic bit is_pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/spm_addr_dec.sv
module spm_addr_dec #(
   parameter int          ADDR_W     = 16,
   parameter int          N_BANKS    = 4,
   parameter int          BANK_WORDS = 16,
   parameter int          OFF_W      = 2,
   parameter int unsigned LOCAL_BASE = 'h1000,
   localparam int         BKW        = $clog2(N_BANKS),
   localparam int         RW         = spm_pkg::idx_w(BANK_WORDS)
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              is_local,
   output logic [BKW-1:0]    bank,
   output logic [RW-1:0]     row
);
   localparam longint SPAN = longint'(N_BANKS) * BANK_WORDS * (2 ** OFF_W);

   logic [ADDR_W:0] off;

   always_comb begin
      off      = {1'b0, addr} - {1'b0, ADDR_W'(LOCAL_BASE)};
      is_local = !off[ADDR_W] && (off < (ADDR_W+1)'(SPAN));
      bank     = off[OFF_W +: BKW];
      row      = off[OFF_W + BKW +: RW];
   end
endmodule

// File: rtl/spm_rr_arb.sv
module spm_rr_arb #(
   parameter  int N  = 4,
   localparam int PW = spm_pkg::idx_w(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   input  logic          adv,
   output logic          win_v,
   output logic [PW-1:0] win_idx
);
   logic [PW-1:0] ptr;
   logic [PW:0]   cand;

   always_comb begin
      win_v   = 1'b0;
      win_idx = '0;
      cand    = '0;
      for (int i = 0; i < N; i++) begin
         cand = {1'b0, ptr} + (PW+1)'(i);
         if (cand >= (PW+1)'(N)) cand = cand - (PW+1)'(N);
         if (!win_v && req[cand[PW-1:0]]) begin
            win_v   = 1'b1;
            win_idx = cand[PW-1:0];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             ptr <= '0;
      else if (adv && win_v)  ptr <= (win_idx == PW'(N - 1)) ? '0 : win_idx + 1'b1;
   end
endmodule

// File: rtl/spm_bank.sv
module spm_bank #(
   parameter  int DATA_W = 32,
   parameter  int DEPTH  = 16,
   localparam int RW     = spm_pkg::idx_w(DEPTH)
) (
   input  logic              clk,
   input  logic              en,
   input  logic              we,
   input  logic [RW-1:0]     row,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (en) begin
         if (we) mem[row] <= wdata;
         else    rdata    <= mem[row];
      end
   end
endmodule

// File: rtl/spm_xbar.sv
module spm_xbar #(
   parameter  int          N_PORTS    = 4,
   parameter  int          N_BANKS    = 4,
   parameter  int          BANK_WORDS = 16,
   parameter  int          ADDR_W     = 16,
   parameter  int          DATA_W     = 32,
   parameter  int unsigned LOCAL_BASE = 'h1000,
   localparam int          PW         = spm_pkg::idx_w(N_PORTS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [N_PORTS-1:0]          req,
   input  logic [N_PORTS-1:0]          we,
   input  logic [N_PORTS*ADDR_W-1:0]   addr,
   input  logic [N_PORTS*DATA_W-1:0]   wdata,
   output logic [N_PORTS-1:0]          gnt,
   output logic [N_PORTS-1:0]          resp_valid,
   output logic [N_PORTS*DATA_W-1:0]   resp_rdata,
   output logic                        ext_req,
   output logic [PW-1:0]               ext_port,
   output logic                        ext_we,
   output logic [ADDR_W-1:0]           ext_addr,
   output logic [DATA_W-1:0]           ext_wdata,
   input  logic                        ext_gnt
);
   localparam int OFF_W = $clog2(DATA_W / 8);
   localparam int BKW   = $clog2(N_BANKS);
   localparam int RW    = spm_pkg::idx_w(BANK_WORDS);

   // elaboration-time parameter checks
   if (!spm_pkg::is_pow2(N_BANKS) || N_BANKS < 2) begin : g_bad_banks
      $error("N_BANKS must be a power of two of at least 2");
   end
   if (N_PORTS < 2) begin : g_bad_ports
      $error("N_PORTS must be at least 2");
   end
   if (!spm_pkg::is_pow2(DATA_W / 8) || (DATA_W % 8) != 0) begin : g_bad_width
      $error("DATA_W must be a power-of-two number of bytes");
   end
   if ((LOCAL_BASE % (DATA_W / 8)) != 0) begin : g_bad_base
      $error("LOCAL_BASE must be word aligned");
   end

   logic [ADDR_W-1:0]  addr_a  [N_PORTS];
   logic [DATA_W-1:0]  wdata_a [N_PORTS];
   logic [BKW-1:0]     bank_a  [N_PORTS];
   logic [RW-1:0]      row_a   [N_PORTS];
   logic [N_PORTS-1:0] loc_vec;

   // address decode per port
   for (genvar p = 0; p < N_PORTS; p++) begin : g_dec
      assign addr_a[p]  = addr[p*ADDR_W +: ADDR_W];
      assign wdata_a[p] = wdata[p*DATA_W +: DATA_W];
      spm_addr_dec #(
         .ADDR_W(ADDR_W), .N_BANKS(N_BANKS), .BANK_WORDS(BANK_WORDS),
         .OFF_W(OFF_W), .LOCAL_BASE(LOCAL_BASE)
      ) u_dec (
         .addr(addr_a[p]), .is_local(loc_vec[p]), .bank(bank_a[p]), .row(row_a[p])
      );
   end

   // per-bank request collection, arbitration and storage
   logic [N_BANKS*N_PORTS-1:0] bank_req;
   logic                       bwin_v   [N_BANKS];
   logic [PW-1:0]              bwin_idx [N_BANKS];
   logic [DATA_W-1:0]          bank_rd  [N_BANKS];

   for (genvar t = 0; t < N_BANKS; t++) begin : g_bank
      logic [N_PORTS-1:0] treq;
      always_comb begin
         for (int p = 0; p < N_PORTS; p++)
            treq[p] = req[p] && loc_vec[p] && (bank_a[p] == BKW'(t));
      end
      assign bank_req[t*N_PORTS +: N_PORTS] = treq;

      spm_rr_arb #(.N(N_PORTS)) u_arb (
         .clk(clk), .rst_n(rst_n), .req(treq), .adv(1'b1),
         .win_v(bwin_v[t]), .win_idx(bwin_idx[t])
      );

      spm_bank #(.DATA_W(DATA_W), .DEPTH(BANK_WORDS)) u_bank (
         .clk(clk), .en(bwin_v[t]), .we(we[bwin_idx[t]]),
         .row(row_a[bwin_idx[t]]), .wdata(wdata_a[bwin_idx[t]]),
         .rdata(bank_rd[t])
      );
   end

   // external pass-through
   logic [N_PORTS-1:0] ext_cand;
   logic               ewin_v;
   logic [PW-1:0]      ewin_idx;

   assign ext_cand = req & ~loc_vec;

   spm_rr_arb #(.N(N_PORTS)) u_ext_arb (
      .clk(clk), .rst_n(rst_n), .req(ext_cand), .adv(ext_gnt),
      .win_v(ewin_v), .win_idx(ewin_idx)
   );

   assign ext_req   = ewin_v;
   assign ext_port  = ewin_idx;
   assign ext_we    = we[ewin_idx];
   assign ext_addr  = addr_a[ewin_idx];
   assign ext_wdata = wdata_a[ewin_idx];

   // grant return with same-word read merging
   always_comb begin
      for (int p = 0; p < N_PORTS; p++) begin
         logic [PW-1:0] w;
         w = bwin_idx[bank_a[p]];
         if (loc_vec[p])
            gnt[p] = req[p] && bwin_v[bank_a[p]] &&
                     ((w == PW'(p)) || (!we[w] && !we[p] && (row_a[p] == row_a[w])));
         else
            gnt[p] = req[p] && ewin_v && (ewin_idx == PW'(p)) && ext_gnt;
      end
   end

   // two-stage response path
   logic [N_PORTS-1:0] s1_v;
   logic [N_PORTS-1:0] s1_rd;
   logic [BKW-1:0]     s1_bank [N_PORTS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_v       <= '0;
         s1_rd      <= '0;
         resp_valid <= '0;
         resp_rdata <= '0;
         for (int p = 0; p < N_PORTS; p++) s1_bank[p] <= '0;
      end else begin
         s1_v       <= gnt & loc_vec;
         s1_rd      <= ~we;
         resp_valid <= s1_v;
         for (int p = 0; p < N_PORTS; p++) begin
            s1_bank[p] <= bank_a[p];
            resp_rdata[p*DATA_W +: DATA_W] <= (s1_v[p] && s1_rd[p]) ? bank_rd[s1_bank[p]] : '0;
         end
      end
   end
endmodule

// File: rtl/spm_xbar_chk.sv
module spm_xbar_chk #(
   parameter int          N_PORTS    = 4,
   parameter int          N_BANKS    = 4,
   parameter int          BANK_WORDS = 16,
   parameter int          ADDR_W     = 16,
   parameter int          DATA_W     = 32,
   parameter int unsigned LOCAL_BASE = 'h1000
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [N_PORTS-1:0]         req,
   input logic [N_PORTS-1:0]         we,
   input logic [N_PORTS-1:0]         gnt,
   input logic [N_PORTS-1:0]         resp_valid,
   input logic                       ext_req,
   input logic [ADDR_W-1:0]          ext_addr,
   input logic [N_PORTS-1:0]         loc_vec,
   input logic [N_BANKS*N_PORTS-1:0] bank_req
);
   localparam longint SPAN = longint'(N_BANKS) * BANK_WORDS * (DATA_W / 8);

   logic [1:0] age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        age <= '0;
      else if (age != 2) age <= age + 1'b1;
   end

   AST_GNT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt & ~req) == '0); // R3

   AST_EXT_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
      ext_req |-> ((longint'(ext_addr) < longint'(LOCAL_BASE)) ||
                   (longint'(ext_addr) >= longint'(LOCAL_BASE) + SPAN))); // R1

   AST_RESP_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2) |-> (resp_valid == $past(gnt & loc_vec, 2))); // R8

   for (genvar t = 0; t < N_BANKS; t++) begin : g_bank_chk
      AST_BANK_NEVER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
         (|bank_req[t*N_PORTS +: N_PORTS]) |-> (|(gnt & bank_req[t*N_PORTS +: N_PORTS]))); // R4

      AST_WRITE_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
         (|(gnt & we & bank_req[t*N_PORTS +: N_PORTS])) |->
            ($countones(gnt & bank_req[t*N_PORTS +: N_PORTS]) == 1)); // R7
   end
endmodule

bind spm_xbar spm_xbar_chk #(
   .N_PORTS(N_PORTS), .N_BANKS(N_BANKS), .BANK_WORDS(BANK_WORDS),
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOCAL_BASE(LOCAL_BASE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req(req), .we(we), .gnt(gnt),
   .resp_valid(resp_valid), .ext_req(ext_req), .ext_addr(ext_addr),
   .loc_vec(loc_vec), .bank_req(bank_req)
);

// File: tb/spm_xbar_bench.sv
module spm_xbar_bench;
   localparam int NP = 4;
   localparam int AW = 16;
   localparam int DW = 32;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NP-1:0]  req = '0, we = '0;
   logic [NP*AW-1:0] addr = '0;
   logic [NP*DW-1:0] wdata = '0;
   logic [NP-1:0]  gnt, resp_valid;
   logic [NP*DW-1:0] resp_rdata;
   logic           ext_req, ext_we;
   logic [1:0]     ext_port;
   logic [AW-1:0]  ext_addr;
   logic [DW-1:0]  ext_wdata;
   logic           ext_gnt = 1'b0;

   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;

   spm_xbar u_spm_xbar (
      .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
      .gnt(gnt), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
      .ext_req(ext_req), .ext_port(ext_port), .ext_we(ext_we), .ext_addr(ext_addr),
      .ext_wdata(ext_wdata), .ext_gnt(ext_gnt)
   );

   function automatic logic [AW-1:0] wa(input int w);
      return AW'(32'h1000 + w * 4);
   endfunction

   function automatic logic [DW-1:0] fval(input int w);
      return 32'h5A00_0000 | DW'(w * 32'h0001_0203 + 7);
   endfunction

   function automatic logic [DW-1:0] rd(input int p);
      return resp_rdata[p*DW +: DW];
   endfunction

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic drv(input int p, input bit r, input bit w, input logic [AW-1:0] a,
                      input logic [DW-1:0] d);
      req[p] = r;
      we[p]  = w;
      addr[p*AW +: AW] = a;
      wdata[p*DW +: DW] = d;
   endtask

   task automatic idle_all();
      for (int p = 0; p < NP; p++) drv(p, 1'b0, 1'b0, '0, '0);
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      idle_all();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [DW-1:0] xv, yv;
      xv = 32'hDEAD_0006;
      yv = 32'hBEEF_0006;

      // R9 reset state
      do_reset();
      step(); #2;
      chk("R9 gnt", DW'(gnt), 0);
      chk("R9 resp_valid", DW'(resp_valid), 0);
      chk("R9 ext_req", DW'(ext_req), 0);

      // R5 R2 fill all 64 words, each port in its own bank
      for (int k = 0; k < 19; k++) begin
         step();
         if (k < 16) for (int p = 0; p < NP; p++) drv(p, 1'b1, 1'b1, wa(4*k+p), fval(4*k+p));
         else idle_all();
         #2;
         if (k < 16) chk("R5 parallel write gnt", DW'(gnt), 32'hF);
         chk("R8 write resp_valid", DW'(resp_valid), (k >= 2 && k < 18) ? 32'hF : 32'h0);
      end

      // R2 R5 R8 rotated read sweep of every word
      for (int k = 0; k < 18; k++) begin
         step();
         if (k < 16) for (int p = 0; p < NP; p++) drv(p, 1'b1, 1'b0, wa(4*k + (p+k)%4), '0);
         else idle_all();
         #2;
         if (k < 16) chk("R5 parallel read gnt", DW'(gnt), 32'hF);
         if (k >= 2) begin
            chk("R8 read resp_valid", DW'(resp_valid), 32'hF);
            for (int p = 0; p < NP; p++)
               chk("R8 R2 read data", rd(p), fval(4*(k-2) + (p+k-2)%4));
         end
      end

      // R3 R4 all ports collide on bank 0, held until granted
      do_reset();
      for (int s = 0; s < 6; s++) begin
         step();
         for (int p = 0; p < NP; p++) drv(p, p >= s, 1'b0, wa(4*p), '0);
         #2;
         chk("R4 R3 serial gnt", DW'(gnt), (s < 4) ? DW'(1 << s) : 32'h0);
         if (s >= 2) begin
            chk("R4 serial resp_valid", DW'(resp_valid), DW'(1 << (s-2)));
            chk("R8 serial data", rd(s-2), fval(4*(s-2)));
         end
      end

      // R3 pointer moves past the last winner
      do_reset();
      step(); idle_all(); drv(2, 1'b1, 1'b0, wa(1), '0); #2;
      chk("R3 first winner", DW'(gnt), 32'h4);
      step(); idle_all();
      drv(0, 1'b1, 1'b0, wa(5), '0); drv(1, 1'b1, 1'b0, wa(9), '0); drv(3, 1'b1, 1'b0, wa(13), '0); #2;
      chk("R3 after port2 goes port3", DW'(gnt), 32'h8);
      step(); drv(3, 1'b0, 1'b0, '0, '0); #2;
      chk("R3 wrap to port0", DW'(gnt), 32'h1);
      step(); drv(0, 1'b0, 1'b0, '0, '0); #2;
      chk("R3 then port1", DW'(gnt), 32'h2);

      // R6 broadcast read of one word
      step(); for (int p = 0; p < NP; p++) drv(p, 1'b1, 1'b0, wa(5), '0); #2;
      chk("R6 broadcast gnt", DW'(gnt), 32'hF);
      step(); idle_all(); step(); #2;
      chk("R6 broadcast resp_valid", DW'(resp_valid), 32'hF);
      for (int p = 0; p < NP; p++) chk("R6 broadcast data", rd(p), fval(5));

      // R7 winning write is not merged with reads of the same word
      do_reset();
      step();
      drv(0, 1'b1, 1'b1, wa(6), xv); drv(1, 1'b1, 1'b0, wa(6), '0);
      drv(2, 1'b1, 1'b0, wa(6), '0); drv(3, 1'b1, 1'b0, wa(7), '0); #2;
      chk("R7 write alone", DW'(gnt), 32'h9);
      step(); drv(0, 1'b0, 1'b0, '0, '0); drv(3, 1'b0, 1'b0, '0, '0); #2;
      chk("R7 R6 readers merged next", DW'(gnt), 32'h6);
      step(); idle_all(); #2;
      chk("R8 mixed resp_valid", DW'(resp_valid), 32'h9);
      chk("R8 other bank data", rd(3), fval(7));
      step(); #2;
      chk("R7 readers resp_valid", DW'(resp_valid), 32'h6);
      chk("R7 reader1 sees write", rd(1), xv);
      chk("R7 reader2 sees write", rd(2), xv);

      // R7 losing write is left out of a read broadcast
      do_reset();
      step();
      drv(0, 1'b1, 1'b0, wa(6), '0); drv(1, 1'b1, 1'b1, wa(6), yv); drv(2, 1'b1, 1'b0, wa(6), '0); #2;
      chk("R7 reads merged without write", DW'(gnt), 32'h5);
      step(); drv(0, 1'b0, 1'b0, '0, '0); drv(2, 1'b0, 1'b0, '0, '0); #2;
      chk("R7 write next", DW'(gnt), 32'h2);
      step(); idle_all(); #2;
      chk("R7 old data port0", rd(0), xv);
      chk("R7 old data port2", rd(2), xv);
      step(); drv(3, 1'b1, 1'b0, wa(6), '0); #2;
      chk("R7 read after write gnt", DW'(gnt), 32'h8);
      step(); idle_all(); step(); #2;
      chk("R8 new data", rd(3), yv);

      // R1 external forwarding and window boundaries
      step(); drv(1, 1'b1, 1'b1, 16'h2000, 32'h1234_5678); ext_gnt = 1'b0; #2;
      chk("R1 ext stalled gnt", DW'(gnt), 32'h0);
      chk("R1 ext_req", DW'(ext_req), 32'h1);
      chk("R1 ext_port", DW'(ext_port), 32'h1);
      chk("R1 ext_addr", DW'(ext_addr), 32'h2000);
      chk("R1 ext_we", DW'(ext_we), 32'h1);
      chk("R1 ext_wdata", ext_wdata, 32'h1234_5678);
      step(); ext_gnt = 1'b1; #2;
      chk("R1 ext granted", DW'(gnt), 32'h2);
      step(); idle_all(); #2;
      chk("R1 ext idle", DW'(ext_req), 32'h0);
      step(); #2;
      chk("R8 no resp for ext", DW'(resp_valid), 32'h0);
      step(); drv(0, 1'b1, 1'b0, 16'h0FFC, '0); drv(3, 1'b1, 1'b0, 16'h10FC, '0); #2;
      chk("R1 below window is ext", DW'(ext_addr), 32'h0FFC);
      chk("R1 boundary gnt", DW'(gnt), 32'h9);
      step(); drv(0, 1'b1, 1'b0, 16'h1100, '0); drv(3, 1'b0, 1'b0, '0, '0); #2;
      chk("R1 above window is ext", DW'(ext_addr), 32'h1100);
      chk("R1 above window gnt", DW'(gnt), 32'h1);
      step(); idle_all(); #2;
      chk("R8 last word resp", DW'(resp_valid), 32'h8);
      chk("R2 last word data", rd(3), fval(63));

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule